// File: doc/BRIEF.md
# Full-Scale Test Tone Source with Audio Selector

This block produces a digital sine test tone at the largest amplitude a 16-bit disc audio sample can hold. For each output channel it chooses either that tone or the decoded disc audio, then sends the chosen word out serially. A phase accumulator steps through a 256-entry signed sine table. Its increment is derived from the tone and sample frequencies, so that a 1 kHz tone at a 44.1 kHz sample rate keeps the correct average pitch even though one period is not a whole number of samples.

Serial timing is set by a bit-rate enable, `bit_en`. One frame is 32 bit periods long: a 16-bit left word followed by a 16-bit right word, each sent MSB first, with `wsel` marking the channel. At the first bit of each frame the block captures both parallel disc words and one tone sample, and the accumulator moves on by one step. The source is chosen again only at the first bit of each word, so a change of selection can never produce a word mixed from two sources. Downstream logic therefore sees the test tone in exactly the same serial format as disc audio.

Top module: `tone_sel_top`

## Requirements
- R1: While reset is held, and after it until the first `bit_en` pulse, `sdata` and `wsel` are both 0.
- R2: Each clock edge with `bit_en` high advances the output by one bit. Words are 16 bits and are sent MSB first; the MSB appears on `sdata` after the pulse that starts the word. The first word after reset is a left word. Words alternate left and right, and `wsel` is 0 for the whole of a left word and 1 for the whole of a right word.
- R3: When disc audio is selected, the left word equals `cd_left` and the right word equals `cd_right`. Both are captured at the pulse that starts the frame, and any later change to them within the frame has no effect.
- R4: For frame n (counting from 0 after reset), the tone sample is round(32767·sin(2π·i/256)), rounded half away from zero. Here i is the top 8 bits of the 24-bit value (n·INC) mod 2^24. Both channels of a frame that select the tone carry this same sample.
- R5: INC = floor((TONE_HZ·2^24 + FS_HZ/2) / FS_HZ). With the defaults (1000, 44100) the left tone words of frames 1 to 441 show exactly 10 rising zero crossings. A rising crossing is a negative sample followed by a non-negative one.
- R6: The tone reaches the full 16-bit scale: +32767 at table index 64 and -32767 at table index 192.
- R7: `use_tone` is sampled only at the pulse that starts a word, where 1 selects the tone and 0 selects disc audio. A change of `use_tone` at any other pulse within that word has no effect on the word.
- R8: The tone phase advances once per frame whatever source is selected, so the tone resumes at the phase of the current frame after disc audio has been selected.
- R9: `sdata` and `wsel` change only after a clock edge at which `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per serial bit period |
| use_tone | input | 1 | Source select: 1 for test tone, 0 for disc audio |
| cd_left | input | 16 | Parallel disc audio word, left channel |
| cd_right | input | 16 | Parallel disc audio word, right channel |
| sdata | output | 1 | Serial audio data, MSB first |
| wsel | output | 1 | Word select: 0 for a left word, 1 for a right word |

## Verification
The bench builds two copies. The first uses the default parameters (24-bit accumulator, 1000 Hz tone, 44100 Hz sample rate) and exercises the real non-integer step, the 1 kHz crossing count, source switching and input latching. The second uses TONE_HZ = 1 and FS_HZ = 256, which makes the increment exactly one table entry per frame. Within 256 frames that copy visits every table entry, including both peaks, so the full table contents and the full-scale amplitude come within reach of the ports.

// File: rtl/tone_sel_pkg.sv
package tone_sel_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int FULL_PEAK = 32767;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
    parameter int ACC_W   = 24,
    parameter int IDX_W   = 8,
    parameter int TONE_HZ = 1000,
    parameter int FS_HZ   = 44100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);

    localparam longint SCALED = (longint'(TONE_HZ) << ACC_W) + longint'(FS_HZ / 2);
    localparam longint INC_L  = SCALED / longint'(FS_HZ);
    localparam logic [63:0] INC_V = 64'(INC_L);
    localparam logic [ACC_W-1:0] INC = INC_V[ACC_W-1:0];

    typedef struct packed {
        logic [ACC_W-1:0] phase;
    } acc_s;

    acc_s acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (step) begin
            acc_d.phase = acc_q.phase + INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign idx = acc_q.phase[ACC_W-1 -: IDX_W];

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom
    import tone_sel_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int AMP   = FULL_PEAK
) (
    input  logic [IDX_W-1:0] idx,
    output sample_t          sample
);

    localparam int  DEPTH  = 1 << IDX_W;
    localparam real TWO_PI = 6.283185307179586;

    function automatic int sine_entry(input int k);
        real v;
        v = real'(AMP) * $sin(TWO_PI * real'(k) / real'(DEPTH));
        if (v >= 0.0) begin
            return $rtoi(v + 0.5);
        end
        return -$rtoi(0.5 - v);
    endfunction

    sample_t tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL = sine_entry(k);
        assign tbl[k] = sample_t'(VAL);
    end

    assign sample = tbl[idx];

endmodule

// File: rtl/tone_word_serializer.sv
module tone_word_serializer
    import tone_sel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                use_tone,
    input  sample_t             tone_now,
    input  logic [SAMPLE_W-1:0] cd_left,
    input  logic [SAMPLE_W-1:0] cd_right,
    output logic                frame_adv,
    output logic                sdata,
    output logic                wsel
);

    localparam int FRAME_BITS = 2 * SAMPLE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int LOW_W      = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] shreg;
        logic                ws;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] hold_tone;
    } ser_s;

    ser_s             ser_d, ser_q;
    logic [CNT_W-1:0] next_cnt;
    logic             frame_start;
    logic             word_start;

    always_comb begin
        ser_d       = ser_q;
        next_cnt    = ser_q.cnt + 1'b1;
        frame_start = bit_en && (ser_q.cnt == LAST);
        word_start  = (next_cnt[LOW_W-1:0] == '0);
        if (bit_en) begin
            ser_d.cnt = next_cnt;
            if (word_start) begin
                ser_d.ws = next_cnt[CNT_W-1];
                if (frame_start) begin
                    ser_d.hold_r    = cd_right;
                    ser_d.hold_tone = tone_now;
                    ser_d.shreg     = use_tone ? tone_now : cd_left;
                end else begin
                    ser_d.shreg     = use_tone ? ser_q.hold_tone : ser_q.hold_r;
                end
            end else begin
                ser_d.shreg = {ser_q.shreg[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q           <= '0;
            ser_q.cnt       <= LAST;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign frame_adv = frame_start;
    assign sdata     = ser_q.shreg[SAMPLE_W-1];
    assign wsel      = ser_q.ws;

endmodule

// File: rtl/tone_sel_top.sv
module tone_sel_top
    import tone_sel_pkg::*;
#(
    parameter int ACC_W   = 24,
    parameter int IDX_W   = 8,
    parameter int TONE_HZ = 1000,
    parameter int FS_HZ   = 44100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                use_tone,
    input  logic [SAMPLE_W-1:0] cd_left,
    input  logic [SAMPLE_W-1:0] cd_right,
    output logic                sdata,
    output logic                wsel
);

    logic [IDX_W-1:0] tab_idx;
    sample_t          tone_now;
    logic             frame_adv;

    tone_phase_acc #(
        .ACC_W  (ACC_W),
        .IDX_W  (IDX_W),
        .TONE_HZ(TONE_HZ),
        .FS_HZ  (FS_HZ)
    ) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .step (frame_adv),
        .idx  (tab_idx)
    );

    tone_sine_rom #(
        .IDX_W(IDX_W),
        .AMP  (FULL_PEAK)
    ) u_rom (
        .idx   (tab_idx),
        .sample(tone_now)
    );

    tone_word_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .use_tone (use_tone),
        .tone_now (tone_now),
        .cd_left  (cd_left),
        .cd_right (cd_right),
        .frame_adv(frame_adv),
        .sdata    (sdata),
        .wsel     (wsel)
    );

endmodule

// File: rtl/tone_sel_checker.sv
module tone_sel_checker #(
    parameter int CNT_W = 5
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic sdata,
    input logic wsel
);

    logic [CNT_W-1:0] pulse_cnt_q;
    logic             started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt_q <= '1;
            started_q   <= 1'b0;
        end else if (bit_en) begin
            pulse_cnt_q <= pulse_cnt_q + 1'b1;
            started_q   <= 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (sdata == 1'b0 && wsel == 1'b0)); // R1

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sdata) && $stable(wsel))); // R9

    AST_WS_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wsel) |-> $past(bit_en)); // R2

    AST_WS_MATCHES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (wsel == pulse_cnt_q[CNT_W-1])); // R2

endmodule

bind tone_sel_top tone_sel_checker #(.CNT_W(5)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_en(bit_en),
    .sdata (sdata),
    .wsel  (wsel)
);

// File: tb/tone_sel_top_bench.sv
`timescale 1ns/1ps
module tone_sel_top_bench;

    localparam real    TWO_PI   = 6.283185307179586;
    localparam longint MAIN_INC = ((longint'(1000) << 24) + 22050) / 44100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        use_tone = 1'b0;
    logic [15:0] cd_left = '0;
    logic [15:0] cd_right = '0;
    logic        sd, ws, sd2, ws2;
    logic        fired = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tone_sel_top u_tone_sel_top (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .use_tone(use_tone),
        .cd_left(cd_left), .cd_right(cd_right), .sdata(sd), .wsel(ws)
    );

    tone_sel_top #(.TONE_HZ(1), .FS_HZ(256)) u_tone_sel_top_sweep (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .use_tone(1'b1),
        .cd_left(16'h1234), .cd_right(16'h4321), .sdata(sd2), .wsel(ws2)
    );

    function automatic int sine_ref(input int i);
        real v;
        v = 32767.0 * $sin(TWO_PI * real'(i) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic logic [15:0] main_tone(input int n);
        longint a;
        a = (longint'(n) * MAIN_INC) % (longint'(1) << 24);
        return 16'(sine_ref(int'(a >> 16)));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard queues filled by the driver
    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          drv_frame = 0;

    always @(posedge clk) fired <= bit_en;

    // monitor for the default instance
    logic [15:0] m_word = '0;
    int          m_bits = 0;
    int          m_k = 0;
    bit          m_wsbad = 0;
    logic        m_last_sd = 1'b0, m_last_ws = 1'b0;
    int          tone_l [0:511];

    always @(negedge clk) begin
        if (rst_n) begin
            if (fired) begin
                m_word = {m_word[14:0], sd};
                if (ws != 1'(m_k % 2)) m_wsbad = 1;
                m_bits++;
                if (m_bits == 16) begin
                    check(!m_wsbad, "R2", "word select level", int'(ws), m_k % 2);
                    if (exp_q.size() == 0) begin
                        check(0, "R2", "unexpected word", int'(m_word), -1);
                    end else begin
                        logic [15:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(m_word == e, t, "serial word", int'(m_word), int'(e));
                    end
                    if (m_k % 2 == 0 && m_k / 2 < 512) tone_l[m_k / 2] = int'($signed(m_word));
                    m_bits  = 0;
                    m_k++;
                    m_wsbad = 0;
                end
                m_last_sd = sd;
                m_last_ws = ws;
            end else begin
                check(sd == m_last_sd && ws == m_last_ws, "R9", "hold without tick",
                      int'({ws, sd}), int'({m_last_ws, m_last_sd}));
            end
        end
    end

    // monitor for the sweep instance: one table step per frame
    logic [15:0] s_word = '0;
    int          s_bits = 0;
    int          s_k = 0;
    int          s_max = -40000;
    int          s_min = 40000;

    always @(negedge clk) begin
        if (rst_n && fired) begin
            s_word = {s_word[14:0], sd2};
            s_bits++;
            if (s_bits == 16) begin
                int e;
                e = sine_ref((s_k / 2) % 256);
                check(int'($signed(s_word)) == e, "R4", "sweep table entry",
                      int'($signed(s_word)), e);
                check(ws2 == 1'(s_k % 2), "R2", "sweep word select", int'(ws2), s_k % 2);
                if (int'($signed(s_word)) > s_max) s_max = int'($signed(s_word));
                if (int'($signed(s_word)) < s_min) s_min = int'($signed(s_word));
                s_bits = 0;
                s_k++;
            end
        end
    end

    task automatic pulse();
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] l, input logic [15:0] r,
                             input bit sel_l, input bit sel_r, input bit glitch,
                             input string tag);
        logic [15:0] t;
        t = main_tone(drv_frame);
        drv_frame++;
        exp_q.push_back(sel_l ? t : l);
        tag_q.push_back(tag);
        exp_q.push_back(sel_r ? t : r);
        tag_q.push_back(tag);
        cd_left  = l;
        cd_right = r;
        use_tone = sel_l;
        pulse();
        cd_left  = ~l;     // R3: ignored after the frame start
        cd_right = ~r;
        for (int i = 1; i < 16; i++) begin
            if (glitch && i == 4) use_tone = ~sel_l;   // R7: mid-word change
            pulse();
        end
        use_tone = sel_r;
        pulse();
        for (int i = 1; i < 16; i++) begin
            if (glitch && i == 3) use_tone = ~sel_r;   // R7: mid-word change
            pulse();
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        int crossings;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        check(sd == 1'b0 && ws == 1'b0, "R1", "in reset", int'({ws, sd}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sd == 1'b0 && ws == 1'b0, "R1", "after reset", int'({ws, sd}), 0);
        check(sd2 == 1'b0 && ws2 == 1'b0, "R1", "sweep after reset", int'({ws2, sd2}), 0);

        // R5: tone-only run over 442 frames
        for (int f = 0; f < 442; f++) run_frame(16'h0000, 16'h0000, 1, 1, 0, "R4");
        repeat (4) @(negedge clk);
        crossings = 0;
        for (int n = 1; n <= 441; n++)
            if (tone_l[n-1] < 0 && tone_l[n] >= 0) crossings++;
        check(crossings == 10, "R5", "rising crossings in 441 frames", crossings, 10);

        // R3: disc audio pass-through, extreme codes
        run_frame(16'h8000, 16'h7FFF, 0, 0, 0, "R3");
        run_frame(16'hA5C3, 16'h0001, 0, 0, 0, "R3");
        // R7: select sampled only at word start
        run_frame(16'h5A5A, 16'hC3A5, 0, 0, 1, "R7");
        run_frame(16'h1357, 16'h2468, 1, 0, 1, "R7");
        run_frame(16'hFFFF, 16'h0F0F, 0, 1, 1, "R7");
        // R8: phase kept running while disc audio was selected
        run_frame(16'h0000, 16'h0000, 1, 1, 0, "R8");
        run_frame(16'h1111, 16'h2222, 0, 0, 0, "R3");
        run_frame(16'h3333, 16'h4444, 1, 1, 1, "R8");
        repeat (4) @(negedge clk);

        check(exp_q.size() == 0, "R2", "words left unsent", exp_q.size(), 0);
        // R6: full-scale peaks seen on the sweep instance
        check(s_max == 32767, "R6", "positive peak", s_max, 32767);
        check(s_min == -32767, "R6", "negative peak", s_min, -32767);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule